// File: doc/BRIEF.md
# Dual-Channel Hiccup Fault Sequencer

This controller decides, cycle by cycle, whether each of two linear regulator channels may drive its external pass device. It watches a power-good flag, an active-low shutdown request per channel and a per-channel undervoltage comparator flag. The undervoltage flag means the channel output has fallen below 80% of nominal. All timing comes from cycle counts on one free-running clock, and every count is a parameter.

A channel whose output collapses after start-up is not held off permanently. The controller enters hiccup mode and pulses that channel's enable briefly, with a much longer rest between pulses at a 1:40 on:off ratio. This limits the heat in the pass device until the short circuit goes away. A single start-up hold-off window prevents a false hiccup entry while the outputs are still ramping. The window belongs to both channels at once. It restarts whenever power becomes good or either channel is switched back on. Undervoltage pulses shorter than a filter window are ignored.

The power-good and shutdown inputs are asynchronous, and each passes through a two-flop synchroniser. The undervoltage flags are expected in the clock domain. Each channel also has a synchronous clear input and reports its hiccup state.

Top module: `dual_hiccup_seq`

## Requirements
- R1: While the synchronised power-good input is low, every `drv_en` bit is 0, and every `hiccup` bit is 0 from one cycle later.
- R2: When a channel's `shdn_n` bit goes low, that channel's `drv_en` bit is 0 two clocks later (synchroniser delay), whatever the channel's state. Its `hiccup` bit is 0 one clock after that.
- R3: A hold-off of HOLD_CYCLES clocks starts when synchronised power-good rises or a synchronised `shdn_n` bit rises. While it runs, no channel enters hiccup mode.
- R4: The hold-off is one timer shared by all channels. A rise of any channel's `shdn_n` reloads it to its full length, even while it is running, and the reload delays hiccup entry on every other channel as well.
- R5: Once the hold-off has expired, an enabled channel whose filtered undervoltage flag is set enters hiccup mode on the next clock. Hiccup mode begins with an off period: `drv_en` is 0 and `hiccup` is 1.
- R6: In hiccup mode `drv_en` is low for OFF_CYCLES clocks and then high for ON_CYCLES clocks, repeating while the fault persists. The defaults give 40 ms off and 1 ms on at 50 MHz, a 1:40 ratio.
- R7: A channel leaves hiccup mode only if its filtered undervoltage flag was clear in at least one cycle of an on period. `drv_en` then stays high, and `hiccup` drops when that on period ends.
- R8: An undervoltage flag must be high for FILT_CYCLES consecutive clocks before it counts. A shorter pulse has no effect on `drv_en` or `hiccup`.
- R9: A one-cycle pulse on a channel's `ch_rst` bit returns that channel to the off state on the next clock. The channel re-enters normal run a clock later if it is still enabled. The other channel is unaffected.
- R10: The asynchronous reset `rst_n` forces every `drv_en` and `hiccup` bit to 0. Its release takes effect through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_ok | input | 1 | Supply above its power-on threshold (asynchronous) |
| shdn_n | input | NCH | Per-channel active-low shutdown request (asynchronous) |
| uv_flag | input | NCH | Per-channel output-below-80% comparator flag |
| ch_rst | input | NCH | Per-channel synchronous active-high clear |
| drv_en | output | NCH | Per-channel drive enable for the control amplifier |
| hiccup | output | NCH | Per-channel hiccup-mode status |

## Verification
Most internal faults in this block show up as timing errors at the ports rather than as wrong levels. An off-by-one in a period counter moves the edge where `drv_en` rises or falls by exactly one clock. The checks therefore sample on both sides of every predicted edge.

A hold-off timer that is not reloaded by the second channel, or not shared between channels, lets a faulted channel drop its enable roughly twenty clocks too early. A sticky or missing "good" sample during the on period either traps a channel in hiccup mode or releases it one on-period early. The fault becomes visible within one hiccup cycle.

A broken glitch filter shows up within a few clocks as an unexpected falling `drv_en`.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_RUN  = 2'd1,
    CH_HOFF = 2'd2,
    CH_HON  = 2'd3
  } ch_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hseq_sync2.sv
module hseq_sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;

endmodule

// File: rtl/hseq_holdoff.sv
module hseq_holdoff #(
  parameter int unsigned NCH         = 2,
  parameter int unsigned HOLD_CYCLES = 3_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pgood_s,
  input  logic [NCH-1:0] chan_on_s,
  output logic           hold_act
);

  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0]  cnt_q, cnt_d;
  logic [NCH-1:0] chan_on_q;
  logic           restart;
  logic           cnt_en;

  assign restart = |(chan_on_s & ~chan_on_q);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!pgood_s || restart) begin
      cnt_d  = HW'(HOLD_CYCLES);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - HW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= HW'(HOLD_CYCLES);
      chan_on_q <= '0;
    end else begin
      chan_on_q <= chan_on_s;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hold_act = (cnt_q != '0);

  // R4
  holdoff_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == HW'(HOLD_CYCLES)));

  // R3
  holdoff_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood_s && !restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - HW'(1)));

endmodule

// File: rtl/hseq_glitch_filt.sv
module hseq_glitch_filt #(
  parameter int unsigned FILT_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_raw,
  output logic uv_flt
);

  localparam int unsigned FW = $clog2(FILT_CYCLES + 1);

  logic [FW-1:0] run_q, run_d;
  logic          sat;

  assign sat = (run_q == FW'(FILT_CYCLES));

  always_comb begin
    if (!uv_raw)  run_d = '0;
    else if (sat) run_d = run_q;
    else          run_d = run_q + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign uv_flt = sat;

  // R8
  filt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_raw |=> !uv_flt);

  // R8
  filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_flt) |-> $past(uv_raw));

endmodule

// File: rtl/hseq_channel.sv
module hseq_channel
  import hseq_pkg::*;
#(
  parameter int unsigned ON_CYCLES  = 50_000,
  parameter int unsigned OFF_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_clr,
  input  logic ena,
  input  logic hold_act,
  input  logic uv_flt,
  output logic drv_en,
  output logic in_hic
);

  localparam int unsigned TMAX = max_u(max_u(ON_CYCLES, OFF_CYCLES), 2);
  localparam int unsigned TW   = $clog2(TMAX);

  ch_state_t     st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          good_q, good_d;
  logic          tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    good_d = good_q;
    if (!ena || ch_clr) begin
      st_d   = CH_OFF;
      tmr_d  = '0;
      good_d = 1'b0;
    end else begin
      case (st_q)
        CH_OFF: st_d = CH_RUN;
        CH_RUN: begin
          if (!hold_act && uv_flt) begin
            st_d  = CH_HOFF;
            tmr_d = TW'(OFF_CYCLES - 1);
          end
        end
        CH_HOFF: begin
          if (tmr_zero) begin
            st_d   = CH_HON;
            tmr_d  = TW'(ON_CYCLES - 1);
            good_d = 1'b0;
          end else begin
            tmr_d = tmr_q - TW'(1);
          end
        end
        CH_HON: begin
          good_d = good_q | !uv_flt;
          if (tmr_zero) begin
            if (good_d) begin
              st_d = CH_RUN;
            end else begin
              st_d  = CH_HOFF;
              tmr_d = TW'(OFF_CYCLES - 1);
            end
          end else begin
            tmr_d = tmr_q - TW'(1);
          end
        end
        default: st_d = CH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_OFF;
      tmr_q  <= '0;
      good_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      good_q <= good_d;
    end
  end

  assign drv_en = ena && (st_q == CH_RUN || st_q == CH_HON);
  assign in_hic = (st_q == CH_HOFF || st_q == CH_HON);

  // R2
  shut_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |=> (st_q == CH_OFF));

  // R3
  no_entry_in_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN && hold_act && ena && !ch_clr) |=> (st_q == CH_RUN));

  // R6
  on_after_full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_HON && $past(st_q) == CH_HOFF) |-> ($past(tmr_q) == '0));

  // R7
  stay_if_never_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_HON && tmr_zero && !good_q && uv_flt && ena && !ch_clr) |=> (st_q == CH_HOFF));

  // R9
  clear_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_clr |=> (st_q == CH_OFF));

endmodule

// File: rtl/dual_hiccup_seq.sv
module dual_hiccup_seq #(
  parameter int unsigned NCH         = 2,
  parameter int unsigned HOLD_CYCLES = 3_000_000,
  parameter int unsigned ON_CYCLES   = 50_000,
  parameter int unsigned OFF_CYCLES  = 2_000_000,
  parameter int unsigned FILT_CYCLES = 100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           por_ok,
  input  logic [NCH-1:0] shdn_n,
  input  logic [NCH-1:0] uv_flag,
  input  logic [NCH-1:0] ch_rst,
  output logic [NCH-1:0] drv_en,
  output logic [NCH-1:0] hiccup
);

  logic [1:0]     rst_pipe;
  logic           rst_int_n;
  logic [NCH:0]   async_s;
  logic           pgood_s;
  logic [NCH-1:0] shdn_s;
  logic [NCH-1:0] ena;
  logic           hold_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  hseq_sync2 #(.WIDTH(NCH + 1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async ({shdn_n, por_ok}),
    .q_sync  (async_s)
  );

  assign pgood_s = async_s[0];
  assign shdn_s  = async_s[NCH:1];
  assign ena     = shdn_s & {NCH{pgood_s}};

  hseq_holdoff #(.NCH(NCH), .HOLD_CYCLES(HOLD_CYCLES)) u_holdoff (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pgood_s   (pgood_s),
    .chan_on_s (shdn_s),
    .hold_act  (hold_act)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic uv_flt;

    hseq_glitch_filt #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .uv_raw (uv_flag[gi]),
      .uv_flt (uv_flt)
    );

    hseq_channel #(.ON_CYCLES(ON_CYCLES), .OFF_CYCLES(OFF_CYCLES)) u_chan (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .ch_clr   (ch_rst[gi]),
      .ena      (ena[gi]),
      .hold_act (hold_act),
      .uv_flt   (uv_flt),
      .drv_en   (drv_en[gi]),
      .in_hic   (hiccup[gi])
    );
  end

  // R1
  pgood_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pgood_s |=> (hiccup == '0));

  // R10
  reset_outputs_chk: assert property (@(posedge clk)
    !rst_int_n |-> (drv_en == '0 && hiccup == '0));

endmodule

// File: tb/dual_hiccup_seq_tb.sv
module dual_hiccup_seq_tb;

  localparam int HOLD = 30;
  localparam int ON   = 2;
  localparam int OFF  = 80;
  localparam int FILT = 3;

  typedef struct {
    int         due;
    logic [1:0] drv;
    logic [1:0] hic;
    string      tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       por_ok;
  logic [1:0] shdn_n;
  logic [1:0] uv_flag;
  logic [1:0] ch_rst;
  logic [1:0] drv_en;
  logic [1:0] hiccup;

  int   cyc;
  int   checks;
  int   errors;
  bit   done;
  exp_t sb_q[$];

  dual_hiccup_seq #(
    .NCH(2), .HOLD_CYCLES(HOLD), .ON_CYCLES(ON),
    .OFF_CYCLES(OFF), .FILT_CYCLES(FILT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .shdn_n(shdn_n),
    .uv_flag(uv_flag), .ch_rst(ch_rst), .drv_en(drv_en), .hiccup(hiccup)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int k, input logic [1:0] drv, input logic [1:0] hic,
                           input string tag);
    exp_t e;
    e.due = cyc + k;
    e.drv = drv;
    e.hic = hic;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (e.due != cyc || drv_en !== e.drv || hiccup !== e.hic) begin
        errors++;
        $display("FAIL %s cyc=%0d drv_en=%b hiccup=%b expected drv_en=%b hiccup=%b",
                 e.tag, cyc, drv_en, hiccup, e.drv, e.hic);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; por_ok = 1'b0; shdn_n = 2'b11; uv_flag = 2'b00; ch_rst = 2'b00;
    wait_neg(2);
    expect_at(1, 2'b00, 2'b00, "R10 reset");
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(6);
    expect_at(4, 2'b00, 2'b00, "R1 power-good low");
    wait_neg(6);

    // power-up with channel 1 faulted
    por_ok = 1'b1; uv_flag = 2'b10;
    expect_at(2,   2'b00, 2'b00, "R1 sync delay");
    expect_at(3,   2'b11, 2'b00, "R3 enabled after power-good");
    expect_at(HOLD + 2, 2'b11, 2'b00, "R3 hold-off suppresses entry");
    expect_at(HOLD + 3, 2'b01, 2'b10, "R5 entry with off period");
    expect_at(HOLD + 3 + OFF - 1, 2'b01, 2'b10, "R6 full off period");
    expect_at(HOLD + 3 + OFF,     2'b11, 2'b10, "R6 on pulse start");
    expect_at(HOLD + 3 + OFF + 1, 2'b11, 2'b10, "R6 on pulse length");
    expect_at(HOLD + 3 + OFF + 2, 2'b01, 2'b10, "R7 stays while faulted");
    wait_neg(HOLD + 3 + OFF + 2);

    // fault removed during off period
    uv_flag = 2'b00;
    expect_at(OFF - 1, 2'b01, 2'b10, "R6 second off period");
    expect_at(OFF,     2'b11, 2'b10, "R7 good on pulse");
    expect_at(OFF + 1, 2'b11, 2'b10, "R7 status held to end of pulse");
    expect_at(OFF + 2, 2'b11, 2'b00, "R7 exit after on pulse");
    wait_neg(OFF + 2);

    // short glitch on channel 1
    uv_flag = 2'b10;
    expect_at(6, 2'b11, 2'b00, "R8 short glitch ignored");
    wait_neg(FILT - 1);
    uv_flag = 2'b00;
    wait_neg(8 - FILT);

    // full-length fault after hold-off
    uv_flag = 2'b10;
    expect_at(FILT,     2'b11, 2'b00, "R8 filter still counting");
    expect_at(FILT + 1, 2'b01, 2'b10, "R5 entry after filter");
    wait_neg(FILT + 1);

    // shutdown both, channel 1 in hiccup
    shdn_n = 2'b00; uv_flag = 2'b00;
    expect_at(1, 2'b01, 2'b10, "R2 sync delay");
    expect_at(2, 2'b00, 2'b10, "R2 enable dropped");
    expect_at(3, 2'b00, 2'b00, "R2 hiccup cleared");
    wait_neg(5);

    // shared hold-off reload
    shdn_n = 2'b01;
    wait_neg(20);
    shdn_n = 2'b11; uv_flag = 2'b01;
    expect_at(2,  2'b01, 2'b00, "R4 channel 1 sync delay");
    expect_at(3,  2'b11, 2'b00, "R4 channel 1 enabled");
    expect_at(20, 2'b11, 2'b00, "R4 reload delays channel 0");
    expect_at(HOLD + 3, 2'b11, 2'b00, "R4 reloaded hold-off still running");
    expect_at(HOLD + 4, 2'b10, 2'b01, "R4 entry after reloaded hold-off");
    wait_neg(HOLD + 4);

    // per-channel clear
    ch_rst = 2'b01;
    expect_at(1, 2'b10, 2'b00, "R9 clear to off");
    expect_at(2, 2'b11, 2'b00, "R9 run after clear");
    expect_at(3, 2'b10, 2'b01, "R9 re-entry with fault present");
    wait_neg(1);
    ch_rst = 2'b00;
    wait_neg(4);

    // power-good lost
    por_ok = 1'b0;
    expect_at(1, 2'b10, 2'b01, "R1 sync delay on loss");
    expect_at(2, 2'b00, 2'b01, "R1 enables dropped");
    expect_at(3, 2'b00, 2'b00, "R1 hiccup cleared");
    wait_neg(5);

    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard has %0d unchecked items", sb_q.size());
    end
    finish_run();
  end

endmodule